// File: doc/BRIEF.md
# Masked Break Condition Comparator

This block is the matching core of one hardware breakpoint channel in an on-chip debug unit. Software loads three 32-bit registers through a small register port: a break address, an address mask and a break data value. A fourth small control register enables the channel, enables the data comparison and picks which of four monitored data sources feeds the data compare. The sources are two 32-bit system buses and two 16-bit memory buses.

Each cycle with a valid access strobe, the block compares the observed address with the break address. Any bit whose mask bit is set is left out of that compare. When the data compare is enabled, the selected bus is also compared with the break data register. The two 16-bit memory buses are checked against opposite halves of that register: the X memory bus against the upper half, the Y memory bus against the lower half. A qualified access produces a one-cycle match pulse in the following cycle.

Top module: `masked_break_matcher`

## Requirements
- R1: After reset, every register reads back zero and `hit` is low.
- R2: Offsets 0, 1 and 2 of the register port hold the break address, the address mask and the break data as full 32-bit values that read back as written. Offset 3 holds the control field in bits [3:0], and its upper bits read as zero. Control bit 0 enables the channel, bit 1 enables the data compare, and bits [3:2] select the data source.
- R3: Address bit n takes part in the compare only while mask bit n is 0. A mask bit of 1 makes that address bit a don't-care.
- R4: `hit` is high for exactly the one cycle after a cycle with `acc_valid` high that meets every enabled condition. It is low after any cycle with `acc_valid` low.
- R5: While the channel-enable bit is 0, `hit` stays low.
- R6: While the data-compare enable bit is 0, only the address decides the match. Bus data is then ignored.
- R7: Select value 0 compares all 32 bits of `bus_a` with the break data. Select value 1 does the same with `bus_b`.
- R8: Select value 2 compares `xmem[15:0]` with break data bits [31:16]. Break data bits [15:0] have no effect.
- R9: Select value 3 compares `ymem[15:0]` with break data bits [15:0]. Break data bits [31:16] have no effect.
- R10: A register write applies from the cycle after the write. An access in the same cycle as the write is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register offset for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register offset for the read |
| rd_data | output | 32 | Read data (combinational) |
| acc_valid | input | 1 | Access strobe for the monitored cycle |
| acc_addr | input | 32 | Address of the monitored access |
| bus_a | input | 32 | First 32-bit system data bus |
| bus_b | input | 32 | Second 32-bit system data bus |
| xmem | input | 16 | X memory data bus |
| ymem | input | 16 | Y memory data bus |
| hit | output | 1 | Registered one-cycle break match pulse |

## Verification
Random configurations mix sparse and dense masks with addresses that either equal the break address with only masked bits flipped, or differ in one unmasked bit. This separates a correct mask from an inverted one or a mask that is ignored. For each select value, the bench sets the unused half of the break data to noise and the other buses to matching values. A wrong steering choice or a swapped half then shows up as a spurious hit or a missed one. Directed cases pair a write with an access in the same cycle, and toggle each enable bit, to pin down when a write takes effect and how each gate acts.

// File: rtl/masked_break_matcher.sv
module masked_break_matcher #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  input  logic [DATA_W/2-1:0] xmem,
  input  logic [DATA_W/2-1:0] ymem,
  output logic              hit
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] brk_addr, brk_mask;
  logic [DATA_W-1:0] brk_data;
  logic              ctl_en, ctl_dce;
  logic [1:0]        ctl_sel;
  logic              addr_ok, data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '0;
      brk_mask <= '0;
      brk_data <= '0;
      ctl_en   <= 1'b0;
      ctl_dce  <= 1'b0;
      ctl_sel  <= 2'd0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: brk_addr <= wr_data[ADDR_W-1:0];
        2'd1: brk_mask <= wr_data[ADDR_W-1:0];
        2'd2: brk_data <= wr_data[DATA_W-1:0];
        default: begin
          ctl_en  <= wr_data[0];
          ctl_dce <= wr_data[1];
          ctl_sel <= wr_data[3:2];
        end
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = 32'(brk_addr);
      2'd1:    rd_data = 32'(brk_mask);
      2'd2:    rd_data = 32'(brk_data);
      default: rd_data = {28'd0, ctl_sel, ctl_dce, ctl_en};
    endcase
  end

  assign addr_ok = ((acc_addr ^ brk_addr) & ~brk_mask) == '0;

  always_comb begin
    case (ctl_sel)
      2'd0:    data_ok = (bus_a == brk_data);
      2'd1:    data_ok = (bus_b == brk_data);
      2'd2:    data_ok = (xmem == brk_data[DATA_W-1:HALF_W]);
      default: data_ok = (ymem == brk_data[HALF_W-1:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= acc_valid & ctl_en & addr_ok & (~ctl_dce | data_ok);
  end
endmodule

module masked_break_matcher_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W/2-1:0] xmem,
  input logic [DATA_W/2-1:0] ymem,
  input logic [ADDR_W-1:0] brk_addr,
  input logic [ADDR_W-1:0] brk_mask,
  input logic [DATA_W-1:0] brk_data,
  input logic              ctl_en,
  input logic              ctl_dce,
  input logic [1:0]        ctl_sel,
  input logic              hit
);
  // R4
  no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);
  // R5
  channel_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !hit);
  // R3
  unmasked_diff_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((acc_addr ^ brk_addr) & ~brk_mask) != '0) |=> !hit);
  // R6
  addr_only_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ctl_en && !ctl_dce && (((acc_addr ^ brk_addr) & ~brk_mask) == '0)) |=> hit);
  // R8
  xmem_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_dce && ctl_sel == 2'd2 && xmem != brk_data[DATA_W-1:DATA_W/2]) |=> !hit);
  // R9
  ymem_lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_dce && ctl_sel == 2'd3 && ymem != brk_data[DATA_W/2-1:0]) |=> !hit);
endmodule

bind masked_break_matcher masked_break_matcher_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .xmem(xmem), .ymem(ymem), .brk_addr(brk_addr), .brk_mask(brk_mask),
  .brk_data(brk_data), .ctl_en(ctl_en), .ctl_dce(ctl_dce), .ctl_sel(ctl_sel),
  .hit(hit));

// File: tb/tb_masked_break_matcher.sv
module tb_masked_break_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [31:0] wr_data = '0, rd_data;
  logic acc_valid = 1'b0;
  logic [31:0] acc_addr = '0, bus_a = '0, bus_b = '0;
  logic [15:0] xmem = '0, ymem = '0;
  logic hit;

  int checks = 0, fails = 0;
  logic [31:0] m_addr = '0, m_mask = '0, m_data = '0;
  logic [3:0]  m_ctl = '0;

  always #4 clk = ~clk;

  masked_break_matcher dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .bus_a(bus_a), .bus_b(bus_b), .xmem(xmem), .ymem(ymem), .hit(hit));

  function automatic logic model_hit(logic [31:0] a, logic [31:0] ba, logic [31:0] bb,
                                     logic [15:0] x, logic [15:0] y);
    logic aok, dok;
    aok = ((a ^ m_addr) & ~m_mask) == 32'd0;
    case (m_ctl[3:2])
      2'd0: dok = (ba == m_data);
      2'd1: dok = (bb == m_data);
      2'd2: dok = (x == m_data[31:16]);
      default: dok = (y == m_data[15:0]);
    endcase
    return m_ctl[0] && aok && (!m_ctl[1] || dok);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: m_addr = d;
      2'd1: m_mask = d;
      2'd2: m_data = d;
      default: m_ctl = d[3:0];
    endcase
  endtask

  task automatic access(string req, logic [31:0] a, logic [31:0] ba, logic [31:0] bb,
                        logic [15:0] x, logic [15:0] y);
    logic e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; bus_a = ba; bus_b = bb; xmem = x; ymem = y;
    e = model_hit(a, ba, bb, x, y);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {31'd0, hit}, {31'd0, e});
    @(negedge clk);
    check("R4 pulse ends", {31'd0, hit}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_sel = i[1:0]; #1;
      check("R1 reset reg", rd_data, 32'd0);
    end
    check("R1 reset hit", {31'd0, hit}, 32'd0);
    rst_n = 1'b1;

    wr(2'd0, 32'hDEAD_BEEF); wr(2'd1, 32'h0F0F_00FF); wr(2'd2, 32'h1234_5678); wr(2'd3, 32'hFFFF_FFFB);
    rd_sel = 2'd0; #1; check("R2 addr rb", rd_data, 32'hDEAD_BEEF);
    rd_sel = 2'd1; #1; check("R2 mask rb", rd_data, 32'h0F0F_00FF);
    rd_sel = 2'd2; #1; check("R2 data rb", rd_data, 32'h1234_5678);
    rd_sel = 2'd3; #1; check("R2 ctl rb", rd_data, 32'h0000_000B);

    // R3: masked bits flipped still hit; unmasked flip misses (ctl=1: enable, addr only)
    wr(2'd3, 32'h1);
    access("R3 masked flip", 32'hDEAD_BEEF ^ 32'h0F0F_00FF, '0, '0, '0, '0);
    check("R3 masked flip hit", {31'd0, model_hit(32'hDEAD_BEEF ^ 32'h0F0F_00FF, 0, 0, 0, 0)}, 32'd1);
    access("R3 unmasked flip", 32'hDEAD_BEEF ^ 32'h0000_0100, '0, '0, '0, '0);
    // R6: data ignored while data compare disabled
    access("R6 addr only", 32'hDEAD_BEEF, 32'h0, 32'h0, 16'h0, 16'h0);
    // R4: no strobe, no hit
    @(negedge clk); acc_addr = 32'hDEAD_BEEF; acc_valid = 1'b0;
    @(negedge clk); check("R4 no strobe", {31'd0, hit}, 32'd0);
    // R5: channel disabled
    wr(2'd3, 32'h0);
    access("R5 disabled", 32'hDEAD_BEEF, '0, '0, '0, '0);
    // R7 bus_a / bus_b
    wr(2'd3, 32'h3);
    access("R7 bus_a match", 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 16'h1234, 16'h5678);
    access("R7 bus_a miss", 32'hDEAD_BEEF, 32'h1234_5679, 32'h1234_5678, 16'h1234, 16'h5678);
    wr(2'd3, 32'h7);
    access("R7 bus_b match", 32'hDEAD_BEEF, 32'h0, 32'h1234_5678, 16'h0, 16'h0);
    access("R7 bus_b miss", 32'hDEAD_BEEF, 32'h1234_5678, 32'h0234_5678, 16'h0, 16'h0);
    // R8 xmem vs upper half, lower half is noise
    wr(2'd3, 32'hB); wr(2'd2, 32'hA5C3_9999);
    access("R8 x match", 32'hDEAD_BEEF, '0, '0, 16'hA5C3, 16'hA5C3);
    access("R8 x vs lower miss", 32'hDEAD_BEEF, '0, '0, 16'h9999, 16'h9999);
    // R9 ymem vs lower half
    wr(2'd3, 32'hF);
    access("R9 y match", 32'hDEAD_BEEF, '0, '0, 16'h9999, 16'h9999);
    access("R9 y vs upper miss", 32'hDEAD_BEEF, '0, '0, 16'hA5C3, 16'hA5C3);
    // R10: write in the same cycle as the access uses old address
    wr(2'd3, 32'h1); wr(2'd1, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_4000;
    acc_valid = 1'b1; acc_addr = 32'h0000_4000;
    @(negedge clk);
    wr_en = 1'b0; acc_valid = 1'b0; m_addr = 32'h0000_4000;
    check("R10 old value used", {31'd0, hit}, 32'd0);
    access("R10 new value used", 32'h0000_4000, '0, '0, '0, '0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ba, mk, dt, a, fa, fb;
      logic [15:0] fx, fy;
      ba = $urandom; dt = $urandom;
      mk = (i % 2 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      wr(2'd0, ba); wr(2'd1, mk); wr(2'd2, dt);
      wr(2'd3, {28'd0, 2'($urandom), ($urandom % 2 == 0), ($urandom % 8 != 0)});
      a = ba ^ ($urandom & mk);
      if ($urandom % 3 == 0 && mk != 32'hFFFF_FFFF) begin
        int b;
        b = int'($urandom % 32);
        while (mk[b]) b = (b + 1) % 32;
        a[b] = ~a[b];
      end
      fa = ($urandom % 2) ? dt : $urandom;
      fb = ($urandom % 2) ? dt : $urandom;
      fx = ($urandom % 2) ? dt[31:16] : 16'($urandom);
      fy = ($urandom % 2) ? dt[15:0]  : 16'($urandom);
      access("R3/R6/R7/R8/R9 random", a, fa, fb, fx, fy);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule